// File: doc/BRIEF.md
# Double-Buffered DAC Code Controller

This block stores the output codes for a bank of DAC channels in two stages. A host writes a channel's code through a simple parallel register port. The code always lands in a staging register, and a separate live register drives the code bus. A per-channel mode bit decides when a staged code moves to the live register. In direct mode the move happens on the same write. In deferred mode the code waits for a shared trigger event, so that many outputs change on one clock edge.

A trigger event comes from one of two sources. The first is a write of 1 to a command bit, which reads back as 0. The second is a rising edge on an external pin. That pin is passed through a two-flop synchronizer and then through a two-state edge detector with states `PIN_LOW` and `PIN_HIGH`. The transition `PIN_LOW -> PIN_HIGH` (synchronized level seen high) produces a one-cycle trigger. The transition `PIN_HIGH -> PIN_LOW` (synchronized level seen low) re-arms the detector, and no other transition exists. Host decode classifies each cycle as `OP_NONE`, `OP_DATA`, `OP_SYNC` or `OP_TRIG`. A reload input from the clamp logic copies every staged code into its live register regardless of mode. A host read of a channel returns the live code, not the staged one.

Register map: channel `c` has its code at address `c` (0 to 7). The mode mask is at 0x10, where bit `c` = 1 puts channel `c` in deferred mode. The trigger command is at 0x11, where bit 0 = 1 fires a trigger.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: After reset every channel's live code is 0 and the mode mask at 0x10 reads 0, so all channels start in direct mode.
- R2: A write to address c of a channel with mode bit 0 shows the written code on that channel's output after the write's clock edge.
- R3: A write to address c of a channel with mode bit 1 changes only the staged code. The output keeps its value until a trigger or a reload.
- R4: Writing bit 0 = 1 at address 0x11 moves the staged code of every deferred channel to its output on that edge, all on the same cycle. Direct channels are not affected, and writing 0 there fires nothing.
- R5: A rising edge on the trigger pin moves all deferred channels on the third rising clock edge after the pin goes high. Holding the pin high gives exactly one transfer.
- R6: A read of address c (0 to 7) returns the live code of channel c, not the staged code.
- R7: Address 0x11 always reads 0, and address 0x10 reads back the mask last written.
- R8: A cycle with the reload input high copies every channel's staged code to its output, whatever its mode.
- R9: When a data write coincides with a pin trigger or a reload, the channel takes the newly written code on that edge.
- R10: Changing a channel's mode bit alone does not move its staged code to the output.
- R11: Writes to unmapped addresses (for example 0x12 or 0x20) change no output and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the current cycle |
| host_addr | input | 6 | Register address for a read or write |
| host_wdata | input | 12 | Write data |
| host_rdata | output | 12 | Read data for host_addr (combinational) |
| trig_pin | input | 1 | Asynchronous external trigger, active on its rising edge |
| reload_all | input | 1 | Copy every staged code to its live register |
| dac_code | output | 96 | Live codes, channel c in bits [12c+11:12c] |

## Verification
The bench sweeps every channel in direct mode with several codes, including all-zero and all-ones, so that a wrong channel index or a dropped bit shows up. It then uses a checkerboard mode mask, which separates channels that must move from channels that must hold under write, command trigger and reads of live against staged values. It fires the pin trigger to check the synchronizer latency cycle by cycle and to show that a held pin does not fire again. It also places a write in the same cycle as a pin trigger and as a reload, which tells whether the transfer path takes the new code or the old one. Mode-only changes and unmapped writes are checked to have no effect on the output.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
    localparam int unsigned MODE_OFS = 'h10;
    localparam int unsigned FIRE_OFS = 'h11;
    localparam int unsigned FIRE_BIT = 0;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_DATA,
        OP_SYNC,
        OP_TRIG
    } host_op_e;
endpackage

// File: rtl/dac_trig_detect.sv
module dac_trig_detect
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_lvl;
    pin_state_e             state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
    end

    assign pin_lvl = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PIN_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_LOW:  if (pin_lvl)  state_d = PIN_HIGH;
            PIN_HIGH: if (!pin_lvl) state_d = PIN_LOW;
            default:  state_d = PIN_LOW;
        endcase
    end

    // outputs
    always_comb begin
        rise_pulse = 1'b0;
        unique case (state_q)
            PIN_LOW:  rise_pulse = pin_lvl;
            PIN_HIGH: rise_pulse = 1'b0;
            default:  rise_pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
    parameter int unsigned CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              deferred,
    input  logic              fire,
    input  logic              reload,
    output logic [CODE_W-1:0] stage_q,
    output logic [CODE_W-1:0] live_q
);
    logic [CODE_W-1:0] stage_d;
    logic              load_live;

    assign stage_d   = wr_hit ? wr_code : stage_q;
    assign load_live = reload | (wr_hit & ~deferred) | (fire & deferred);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            live_q  <= '0;
        end else begin
            stage_q <= stage_d;
            if (load_live) live_q <= stage_d;
        end
    end
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        wr_sel,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic [NUM_CH-1:0]        mode_mask,
    input  logic                     fire,
    input  logic                     reload,
    output logic [NUM_CH*CODE_W-1:0] stage_flat,
    output logic [NUM_CH*CODE_W-1:0] live_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dac_chan_reg #(.CODE_W(CODE_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_sel[g]),
            .wr_code  (wr_code),
            .deferred (mode_mask[g]),
            .fire     (fire),
            .reload   (reload),
            .stage_q  (stage_flat[g*CODE_W +: CODE_W]),
            .live_q   (live_flat[g*CODE_W +: CODE_W])
        );
    end
endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
    import dac_dbuf_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned CODE_W      = 12,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [CODE_W-1:0]        host_wdata,
    output logic [CODE_W-1:0]        host_rdata,
    input  logic                     trig_pin,
    input  logic                     reload_all,
    output logic [NUM_CH*CODE_W-1:0] dac_code
);
    localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(MODE_OFS);
    localparam logic [ADDR_W-1:0] A_FIRE = ADDR_W'(FIRE_OFS);
    localparam logic [ADDR_W-1:0] A_NCH  = ADDR_W'(NUM_CH);

    host_op_e                 op;
    logic [NUM_CH-1:0]        wr_sel;
    logic [NUM_CH-1:0]        mode_q;
    logic                     sw_fire;
    logic                     pin_rise;
    logic                     trig_evt;
    logic [NUM_CH*CODE_W-1:0] stage_flat;
    logic [NUM_CH*CODE_W-1:0] live_flat;
    logic                     unused_wdata;

    assign unused_wdata = ^host_wdata;

    // host cycle classification
    always_comb begin
        op = OP_NONE;
        if (host_wr) begin
            if (host_addr < A_NCH)        op = OP_DATA;
            else if (host_addr == A_MODE) op = OP_SYNC;
            else if (host_addr == A_FIRE) op = OP_TRIG;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        assign wr_sel[g] = (op == OP_DATA) && (host_addr == ADDR_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              mode_q <= '0;
        else if (op == OP_SYNC)  mode_q <= host_wdata[NUM_CH-1:0];
    end

    assign sw_fire  = (op == OP_TRIG) && host_wdata[FIRE_BIT];
    assign trig_evt = sw_fire | pin_rise;

    dac_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_async  (trig_pin),
        .rise_pulse (pin_rise)
    );

    dac_reg_bank #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .wr_code    (host_wdata),
        .mode_mask  (mode_q),
        .fire       (trig_evt),
        .reload     (reload_all),
        .stage_flat (stage_flat),
        .live_flat  (live_flat)
    );

    // readback: live codes, mode mask, command reads zero
    always_comb begin
        host_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (host_addr == ADDR_W'(c)) host_rdata = live_flat[c*CODE_W +: CODE_W];
        end
        if (host_addr == A_MODE) host_rdata = CODE_W'(mode_q);
    end

    assign dac_code = live_flat;
endmodule

module dac_dbuf_chk #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned ADDR_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     host_wr,
    input logic [ADDR_W-1:0]        host_addr,
    input logic [CODE_W-1:0]        host_wdata,
    input logic [CODE_W-1:0]        host_rdata,
    input logic                     reload_all,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        mode_q,
    input logic                     trig_evt,
    input logic                     pin_rise,
    input logic [NUM_CH*CODE_W-1:0] stage_flat
);
    localparam logic [ADDR_W-1:0] A_FIRE = ADDR_W'(dac_dbuf_pkg::FIRE_OFS);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R2
        direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (host_wr && host_addr == ADDR_W'(g) && !mode_q[g])
            |=> dac_code[g*CODE_W +: CODE_W] == $past(host_wdata));

        // R3
        deferred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[g] && !trig_evt && !reload_all)
            |=> $stable(dac_code[g*CODE_W +: CODE_W]));

        // R8
        reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reload_all && !host_wr)
            |=> dac_code[g*CODE_W +: CODE_W] == $past(stage_flat[g*CODE_W +: CODE_W]));
    end

    // R5
    pin_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rise |=> !pin_rise);

    // R7
    fire_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == A_FIRE) |-> host_rdata == '0);
endmodule

bind dac_dbuf_ctrl dac_dbuf_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .reload_all (reload_all),
    .dac_code   (dac_code),
    .mode_q     (mode_q),
    .trig_evt   (trig_evt),
    .pin_rise   (pin_rise),
    .stage_flat (stage_flat)
);

// File: tb/dac_dbuf_ctrl_test.sv
module dac_dbuf_ctrl_test;
    localparam int NCH = 8;
    localparam int CW  = 12;
    localparam int AW  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_wr = 1'b0;
    logic [AW-1:0]   host_addr = '0;
    logic [CW-1:0]   host_wdata = '0;
    logic [CW-1:0]   host_rdata;
    logic            trig_pin = 1'b0;
    logic            reload_all = 1'b0;
    logic [NCH*CW-1:0] dac_code;

    int total = 0;
    int bad   = 0;

    logic [CW-1:0]  m_live  [NCH];
    logic [CW-1:0]  m_stage [NCH];
    logic [NCH-1:0] m_mode;

    always #2 clk = ~clk;

    dac_dbuf_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .trig_pin   (trig_pin),
        .reload_all (reload_all),
        .dac_code   (dac_code)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < NCH; c++) chk(tag, 32'(dac_code[c*CW +: CW]), 32'(m_live[c]));
    endtask

    task automatic read_chk(int addr, logic [31:0] exp, string tag);
        host_addr = AW'(addr);
        #1;
        chk(tag, 32'(host_rdata), exp);
    endtask

    function automatic void model_fire();
        for (int c = 0; c < NCH; c++) if (m_mode[c]) m_live[c] = m_stage[c];
    endfunction

    // drives one write cycle and applies the same write to the model
    task automatic host_write(int addr, logic [CW-1:0] d);
        host_wr = 1'b1; host_addr = AW'(addr); host_wdata = d;
        if (addr < NCH) begin
            m_stage[addr] = d;
            if (!m_mode[addr]) m_live[addr] = d;
        end else if (addr == 'h10) begin
            m_mode = d[NCH-1:0];
        end else if (addr == 'h11 && d[0]) begin
            model_fire();
        end
        tick();
        host_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_live[c] = '0; m_stage[c] = '0; end
        m_mode = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check_all("R1 reset code");
        read_chk('h10, 0, "R1 mode mask reset");

        // R2 / R6 direct-mode sweep over all channels and several codes
        for (int c = 0; c < NCH; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [CW-1:0] v;
                v = (p == 0) ? 12'hFFF : (p == 1) ? 12'h000 : CW'(c * 293 + p * 1111 + 5);
                host_write(c, v);
                check_all("R2 direct write");
                read_chk(c, 32'(v), "R6 readback direct");
            end
        end

        // R3 / R6 checkerboard mode mask
        host_write('h10, 12'h0AA);
        read_chk('h10, 32'h0AA, "R7 mode mask readback");
        for (int c = 0; c < NCH; c++) host_write(c, CW'(12'h400 + c * 77));
        check_all("R3 deferred hold / R2 direct");
        for (int c = 1; c < NCH; c += 2) read_chk(c, 32'(m_live[c]), "R6 readback live not staged");

        // R4 command trigger
        host_write('h11, 12'h000);
        check_all("R4 zero write no fire");
        host_write('h11, 12'h001);
        check_all("R4 command fire");
        read_chk('h11, 0, "R7 fire reads zero");

        // R5 pin trigger latency and one-shot
        host_write('h10, 12'h0FF);
        for (int c = 0; c < NCH; c++) host_write(c, CW'(12'h800 + c * 13));
        check_all("R3 all deferred hold");
        trig_pin = 1'b1;
        tick(); tick();
        check_all("R5 no transfer before third edge");
        tick();
        model_fire();
        check_all("R5 transfer on third edge");
        host_write(0, 12'h5A5);
        repeat (5) tick();
        check_all("R5 held pin no retrigger");
        trig_pin = 1'b0;
        repeat (3) tick();

        // R9 write in the same cycle as a pin trigger
        trig_pin = 1'b1;
        tick(); tick();
        host_write(1, 12'h3C3);
        model_fire();
        check_all("R9 write with pin fire");
        trig_pin = 1'b0;
        repeat (3) tick();

        // R10 mode change alone moves nothing
        host_write(2, 12'hABC);
        host_write('h10, 12'h000);
        repeat (2) tick();
        check_all("R10 mode change no move");

        // R8 reload regardless of mode, R9 write with reload
        host_write('h10, 12'h0FF);
        host_write(3, 12'h111);
        host_write(4, 12'h222);
        check_all("R3 staged before reload");
        reload_all = 1'b1;
        tick();
        reload_all = 1'b0;
        for (int c = 0; c < NCH; c++) m_live[c] = m_stage[c];
        check_all("R8 reload copies all");
        reload_all = 1'b1;
        host_write(5, 12'h999);
        reload_all = 1'b0;
        m_live[5] = 12'h999;
        check_all("R9 write with reload");

        // R11 unmapped addresses
        host_write('h12, 12'hFFF);
        host_write('h20, 12'h123);
        host_write('h3F, 12'h0F0);
        check_all("R11 unmapped write");
        read_chk('h10, 32'h0FF, "R11 mode mask untouched");
        host_write('h11, 12'h001);
        check_all("R11 no staged change from unmapped");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule